// File: doc/BRIEF.md
# Physical Region Pointer List Walker

This block turns the two region pointers of a storage command, together with its byte length, into a stream of host page addresses. It emits one address for each data page. The first pointer may start part-way into a page. When the first pointer and one more page cover the transfer, the second pointer is itself the last page address. Otherwise the second pointer names a list page in host memory. The block fetches that list through a read-request/response port and emits its entries in order. When a list runs out, its final slot is followed as a link to the next list.

A host read that fails while a list page is being fetched ends the walk at once. The block then reports a data-transfer-error status and emits no more addresses. Each command ends in exactly one single-cycle pulse: done or error. A new command is taken only while the block is idle. The page size exponent and the number of entries per list are parameters. The block does not check pointer alignment, does not move payload data and does not handle scatter-gather descriptors.

Top module: `prp_walker`

## Requirements
- R1: While reset is held and after it is released, cmd_ready is 1 and out_valid, rd_req_valid, walk_done and walk_err are all 0.
- R2: A command of length 0 emits no address and issues no read. walk_done pulses in the cycle after acceptance.
- R3: The first address is cmd_prp1. It covers the page size minus the in-page offset of cmd_prp1, but never more than the length. If that covers the whole length, it is the only address.
- R4: If the bytes left after the first page are at most one page, the second and last address is cmd_prp2, and no read is issued.
- R5: Otherwise cmd_prp2 is the address of a list. One read is issued with rd_req_addr equal to the list address and rd_req_cnt equal to the smaller of MAX_ENTS and the bytes left rounded up to whole pages. Each response beat is one 64-bit entry, and the entries are emitted in beat order.
- R6: When the walk reaches entry index MAX_ENTS-1 of a list and more than one page is still left, that entry is not emitted. It is read as the address of the next list, which is fetched with the rule of R5, and the walk restarts at index 0.
- R7: A response beat with rd_rsp_err set causes walk_err to pulse in the next cycle, with walk_status 8'h04. No further address is emitted. cmd_ready stays 0 until the remaining beats of that read have arrived.
- R8: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_addr does not change in the next cycle. An address is taken only in a cycle with both high.
- R9: walk_done pulses for one cycle, with walk_status 8'h00, in the cycle after the last address is taken. cmd_ready is 1 in that same cycle, so a command held on the input is accepted in that cycle.
- R10: Every accepted command ends with exactly one pulse, either walk_done or walk_err, never both in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command taken when both high |
| cmd_prp1 | input | ADDR_W | First region pointer, may carry an in-page offset |
| cmd_prp2 | input | ADDR_W | Second region pointer: a page address or a list address |
| cmd_len | input | LEN_W | Transfer length in bytes |
| rd_req_valid | output | 1 | List read request |
| rd_req_ready | input | 1 | Memory accepts the request |
| rd_req_addr | output | ADDR_W | Byte address of the first entry to read |
| rd_req_cnt | output | CNT_W | Number of 64-bit entries requested |
| rd_rsp_valid | input | 1 | One response beat |
| rd_rsp_data | input | ADDR_W | Entry value of the beat |
| rd_rsp_err | input | 1 | The beat failed |
| out_valid | output | 1 | Page address offered |
| out_ready | input | 1 | Consumer takes the address |
| out_addr | output | ADDR_W | Page address |
| walk_done | output | 1 | Walk finished normally, one cycle |
| walk_err | output | 1 | Walk aborted on a read error, one cycle |
| walk_status | output | 8 | 8'h00 after done, 8'h04 after error |

## Verification
Two events can fall in the same cycle: the completion pulse of one walk and the acceptance of the next command. To provoke this, the bench keeps a second command on the input for the whole of a chained walk. It checks that cmd_ready first comes back in the very cycle walk_done is high, and that both walks then produce their full, correct address sequences back to back. The bench also raises an error pulse while the beats of the failed read are still arriving. It checks that the block refuses commands until those beats have been absorbed.

// File: rtl/prp_walk_pkg.sv
// Shared types for the region pointer walker.
// Assumes nothing beyond IEEE 1800-2017 packages.
package prp_walk_pkg;
    typedef enum logic [2:0] {
        W_IDLE,
        W_FIRST,
        W_SECOND,
        W_REQ,
        W_RSP,
        W_WALK,
        W_DRAIN
    } walk_st_e;

    localparam logic [7:0] STS_OK       = 8'h00;
    localparam logic [7:0] STS_XFER_ERR = 8'h04;
endpackage

// File: rtl/prp_page_math.sv
// Page arithmetic for the walker: bytes covered by the current page and
// pages still needed for the remaining length.
// Assumes LEN_W > PAGE_BITS; purely combinational.
module prp_page_math #(
    parameter int PAGE_BITS = 12,
    parameter int LEN_W     = 32
) (
    input  logic [LEN_W-1:0]     rem_i,
    input  logic [PAGE_BITS-1:0] offs_i,
    output logic [LEN_W-1:0]     take_o,
    output logic [LEN_W-1:0]     ents_o,
    output logic                 one_page_o
);
    localparam logic [LEN_W:0] PAGE = (LEN_W+1)'(1) << PAGE_BITS;

    logic [LEN_W:0] room;
    logic [LEN_W:0] take_w;
    logic [LEN_W:0] ents_w;
    logic           unused_top;

    // room in the current page, the part of it used, and pages left
    always_comb begin
        room       = PAGE - (LEN_W+1)'(offs_i);
        take_w     = ({1'b0, rem_i} < room) ? {1'b0, rem_i} : room;
        ents_w     = ({1'b0, rem_i} + PAGE - 1'b1) >> PAGE_BITS;
        one_page_o = ({1'b0, rem_i} <= PAGE);
    end

    assign take_o     = take_w[LEN_W-1:0];
    assign ents_o     = ents_w[LEN_W-1:0];
    assign unused_top = take_w[LEN_W] ^ ents_w[LEN_W];
endmodule

// File: rtl/prp_list_buf.sv
// Holds the entries of one fetched list page. It is written in beat order
// and read by index. Assumes the memory never sends more beats than requested.
module prp_list_buf #(
    parameter int MAX_ENTS = 8,
    parameter int ADDR_W   = 64,
    parameter int IDX_W    = $clog2(MAX_ENTS),
    parameter int CNT_W    = $clog2(MAX_ENTS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              beat_valid_i,
    input  logic [ADDR_W-1:0] beat_data_i,
    input  logic [IDX_W-1:0]  rd_idx_i,
    output logic [ADDR_W-1:0] rd_data_o,
    output logic [CNT_W-1:0]  got_o
);
    logic [ADDR_W-1:0] ents [MAX_ENTS];
    logic              wr_en;

    assign wr_en = beat_valid_i && (got_o < CNT_W'(MAX_ENTS));

    // beat counter, cleared for each new fetch
    always_ff @(posedge clk) begin
        if (!rst_n)       got_o <= '0;
        else if (clear_i) got_o <= '0;
        else if (wr_en)   got_o <= got_o + 1'b1;
    end

    // entry storage, written at the beat position
    always_ff @(posedge clk) begin
        if (wr_en) ents[got_o[IDX_W-1:0]] <= beat_data_i;
    end

    assign rd_data_o = ents[rd_idx_i];

    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid_i |-> (got_o < CNT_W'(MAX_ENTS)));
endmodule

// File: rtl/prp_walker.sv
// Region pointer walker. From two pointers and a byte length it emits one
// page address per data page. It fetches list pages, follows the last slot
// of a full list as a link, and aborts with a transfer-error status on a
// failed read. Assumes that a read returns exactly the requested number of
// beats and that pointers are aligned as the host requires.
module prp_walker
    import prp_walk_pkg::*;
#(
    parameter int ADDR_W    = 64,
    parameter int LEN_W     = 32,
    parameter int PAGE_BITS = 12,
    parameter int MAX_ENTS  = 8,
    parameter int CNT_W     = $clog2(MAX_ENTS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [ADDR_W-1:0] cmd_prp1,
    input  logic [ADDR_W-1:0] cmd_prp2,
    input  logic [LEN_W-1:0]  cmd_len,
    output logic              rd_req_valid,
    input  logic              rd_req_ready,
    output logic [ADDR_W-1:0] rd_req_addr,
    output logic [CNT_W-1:0]  rd_req_cnt,
    input  logic              rd_rsp_valid,
    input  logic [ADDR_W-1:0] rd_rsp_data,
    input  logic              rd_rsp_err,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [ADDR_W-1:0] out_addr,
    output logic              walk_done,
    output logic              walk_err,
    output logic [7:0]        walk_status
);
    localparam int IDX_W   = $clog2(MAX_ENTS);
    localparam int PAGE_SZ = 1 << PAGE_BITS;

    walk_st_e          state;
    logic [LEN_W-1:0]  rem_q;
    logic [ADDR_W-1:0] prp1_q, prp2_q, base_q;
    logic [IDX_W-1:0]  idx_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              done_q, err_q;
    logic [7:0]        sts_q;

    logic [PAGE_BITS-1:0] offs;
    logic [LEN_W-1:0]     take, ents, rem_next;
    logic                 one_page, is_chain, fire, beat_in, last_beat;
    logic [CNT_W-1:0]     cnt_sel, got;
    logic [ADDR_W-1:0]    ent;
    logic                 unused_ents;

    // only the first page honours the in-page offset
    assign offs = (state == W_FIRST) ? prp1_q[PAGE_BITS-1:0] : '0;

    prp_page_math #(.PAGE_BITS(PAGE_BITS), .LEN_W(LEN_W)) u_math (
        .rem_i     (rem_q),
        .offs_i    (offs),
        .take_o    (take),
        .ents_o    (ents),
        .one_page_o(one_page)
    );

    prp_list_buf #(.MAX_ENTS(MAX_ENTS), .ADDR_W(ADDR_W), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_buf (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_i     (state == W_REQ),
        .beat_valid_i(beat_in),
        .beat_data_i (rd_rsp_data),
        .rd_idx_i    (idx_q),
        .rd_data_o   (ent),
        .got_o       (got)
    );

    // derived walk conditions and port drives
    always_comb begin
        rem_next  = rem_q - take;
        cnt_sel   = (ents >= LEN_W'(MAX_ENTS)) ? CNT_W'(MAX_ENTS) : ents[CNT_W-1:0];
        is_chain  = (idx_q == IDX_W'(MAX_ENTS - 1)) && !one_page;
        out_valid = (state == W_FIRST) || (state == W_SECOND) ||
                    ((state == W_WALK) && !is_chain);
        case (state)
            W_FIRST:  out_addr = prp1_q;
            W_SECOND: out_addr = prp2_q;
            default:  out_addr = ent;
        endcase
        fire      = out_valid && out_ready;
        beat_in   = rd_rsp_valid && ((state == W_RSP) || (state == W_DRAIN));
        last_beat = beat_in && ((got + 1'b1) == cnt_q);
    end

    assign unused_ents  = ^ents;
    assign cmd_ready    = (state == W_IDLE);
    assign rd_req_valid = (state == W_REQ);
    assign rd_req_addr  = base_q;
    assign rd_req_cnt   = cnt_sel;
    assign walk_done    = done_q;
    assign walk_err     = err_q;
    assign walk_status  = sts_q;

    // walk sequencer with one-cycle completion and abort pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= W_IDLE;
            rem_q  <= '0;
            prp1_q <= '0;
            prp2_q <= '0;
            base_q <= '0;
            idx_q  <= '0;
            cnt_q  <= '0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
            sts_q  <= STS_OK;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            case (state)
                W_IDLE: if (cmd_valid) begin
                    prp1_q <= cmd_prp1;
                    prp2_q <= cmd_prp2;
                    rem_q  <= cmd_len;
                    if (cmd_len == '0) begin
                        done_q <= 1'b1;
                        sts_q  <= STS_OK;
                    end else begin
                        state <= W_FIRST;
                    end
                end
                W_FIRST: if (fire) begin
                    rem_q <= rem_next;
                    if (rem_next == '0) begin
                        done_q <= 1'b1;
                        sts_q  <= STS_OK;
                        state  <= W_IDLE;
                    end else if (rem_next <= LEN_W'(PAGE_SZ)) begin
                        state <= W_SECOND;
                    end else begin
                        base_q <= prp2_q;
                        state  <= W_REQ;
                    end
                end
                W_SECOND: if (fire) begin
                    rem_q  <= rem_next;
                    done_q <= 1'b1;
                    sts_q  <= STS_OK;
                    state  <= W_IDLE;
                end
                W_REQ: if (rd_req_ready) begin
                    cnt_q <= cnt_sel;
                    idx_q <= '0;
                    state <= W_RSP;
                end
                W_RSP: if (beat_in && rd_rsp_err) begin
                    err_q <= 1'b1;
                    sts_q <= STS_XFER_ERR;
                    state <= last_beat ? W_IDLE : W_DRAIN;
                end else if (last_beat) begin
                    state <= W_WALK;
                end
                W_WALK: if (is_chain) begin
                    base_q <= ent;
                    state  <= W_REQ;
                end else if (fire) begin
                    rem_q <= rem_next;
                    idx_q <= idx_q + 1'b1;
                    if (rem_next == '0) begin
                        done_q <= 1'b1;
                        sts_q  <= STS_OK;
                        state  <= W_IDLE;
                    end
                end
                W_DRAIN: if (last_beat || (got == cnt_q)) state <= W_IDLE;
                default: state <= W_IDLE;
            endcase
        end
    end

    // R8
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_addr)));
    // R10
    end_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(walk_done && walk_err));
    // R7
    err_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        walk_err |-> (!out_valid && (walk_status == STS_XFER_ERR)));
    // R5
    req_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_valid |-> ((rd_req_cnt != '0) && (rd_req_cnt <= CNT_W'(MAX_ENTS))));
    // R9
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        walk_done |-> (cmd_ready && (walk_status == STS_OK)));
    // R8
    rem_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (rem_q < $past(rem_q)));
endmodule

// File: tb/prp_walker_bench.sv
`timescale 1ns/1ps
module prp_walker_bench;
    localparam int AW = 64;
    localparam int LW = 32;
    localparam int PB = 12;
    localparam int MAXE = 4;
    localparam int CW = $clog2(MAXE + 1);
    localparam int PG = 1 << PB;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0;
    logic cmd_ready;
    logic [AW-1:0] cmd_prp1 = '0, cmd_prp2 = '0;
    logic [LW-1:0] cmd_len = '0;
    logic rd_req_valid, rd_req_ready;
    logic [AW-1:0] rd_req_addr;
    logic [CW-1:0] rd_req_cnt;
    logic rd_rsp_valid = 1'b0, rd_rsp_err = 1'b0;
    logic [AW-1:0] rd_rsp_data = '0;
    logic out_valid, out_ready = 1'b1;
    logic [AW-1:0] out_addr;
    logic walk_done, walk_err;
    logic [7:0] walk_status;

    always #4 clk = ~clk;

    prp_walker #(.ADDR_W(AW), .LEN_W(LW), .PAGE_BITS(PB), .MAX_ENTS(MAXE)) u_prp_walker (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_prp1(cmd_prp1), .cmd_prp2(cmd_prp2), .cmd_len(cmd_len),
        .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
        .rd_req_addr(rd_req_addr), .rd_req_cnt(rd_req_cnt),
        .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data), .rd_rsp_err(rd_rsp_err),
        .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
        .walk_done(walk_done), .walk_err(walk_err), .walk_status(walk_status)
    );

    int nchk = 0, nfail = 0;
    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // host memory: 4096 words; list page k links to page k+1 in its last slot
    logic [63:0] mem_w [0:4095];
    logic [3:0] err_page = 4'd8;
    initial begin
        for (int a = 0; a < 4096; a++) mem_w[a] = 64'h8000_0000 + (64'(a) << 12);
        for (int k = 1; k < 8; k++) mem_w[(k << 9) + MAXE - 1] = 64'(k + 1) << 12;
    end

    logic [63:0] m_addr = '0;
    int m_left = 0, m_wait = 0;
    assign rd_req_ready = (m_left == 0);
    always @(posedge clk) begin
        rd_rsp_valid <= 1'b0;
        if (!rst_n) begin
            m_left <= 0;
        end else if (rd_req_valid && rd_req_ready) begin
            m_addr <= rd_req_addr;
            m_left <= int'(rd_req_cnt);
            m_wait <= 2;
        end else if (m_left != 0) begin
            if (m_wait != 0) m_wait <= m_wait - 1;
            else begin
                rd_rsp_valid <= 1'b1;
                rd_rsp_data  <= mem_w[m_addr[14:3]];
                rd_rsp_err   <= ({1'b0, m_addr[14:12]} == err_page);
                m_addr <= m_addr + 64'd8;
                m_left <= m_left - 1;
            end
        end
    end

    // consumer back-pressure pattern, changed at the rising edge
    int cyc = 0;
    always @(posedge clk) begin
        cyc <= cyc + 1;
        out_ready <= ((cyc % 4) != 3);
    end

    // monitor at the falling edge
    logic [63:0] got_addr [0:63];
    int gn = 0, nreq = 0, ndone = 0, nerr = 0;
    logic [63:0] last_req_addr = '0;
    int last_req_cnt = 0;
    logic [7:0] last_sts = '0;
    logic prev_stall = 1'b0;
    logic [63:0] prev_addr = '0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_stall) chk(out_valid && (out_addr == prev_addr), "R8 hold", out_addr, prev_addr);
            prev_stall = out_valid && !out_ready;
            prev_addr  = out_addr;
            if (out_valid && out_ready && gn < 64) begin got_addr[gn] = out_addr; gn++; end
            if (rd_req_valid && rd_req_ready) begin
                nreq++; last_req_addr = rd_req_addr; last_req_cnt = int'(rd_req_cnt);
            end
            if (walk_done) begin ndone++; last_sts = walk_status; end
            if (walk_err)  begin nerr++;  last_sts = walk_status; end
        end
    end

    // reference model of the walk
    logic [63:0] exp_a [0:63];
    int en = 0, ereq = 0;
    bit e_err = 0;
    task automatic ref_walk(input logic [63:0] p1, input logic [63:0] p2, input int unsigned len, input int ep);
        int unsigned rem, take, i;
        logic [63:0] base;
        e_err = 0;
        rem = len;
        if (rem == 0) return;
        take = PG - int'(p1 % PG);
        if (take > rem) take = rem;
        exp_a[en] = p1; en++;
        rem -= take;
        if (rem == 0) return;
        if (rem <= PG) begin exp_a[en] = p2; en++; return; end
        base = p2; i = 0; ereq++;
        if (int'(base >> 12) == ep) begin e_err = 1; return; end
        while (rem > 0) begin
            if (i == MAXE - 1 && rem > PG) begin
                base = mem_w[(base >> 3) + i]; i = 0; ereq++;
                if (int'(base >> 12) == ep) begin e_err = 1; return; end
            end else begin
                exp_a[en] = mem_w[(base >> 3) + i]; en++;
                rem -= (rem > PG) ? PG : rem;
                i++;
            end
        end
    endtask

    task automatic send_cmd(input logic [63:0] p1, input logic [63:0] p2, input logic [31:0] len);
        @(negedge clk);
        cmd_prp1 = p1; cmd_prp2 = p2; cmd_len = len; cmd_valid = 1'b1;
        for (int w = 0; w < 5000 && !cmd_ready; w++) @(negedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_end(input int ends0, input bit drain_chk);
        for (int w = 0; w < 5000 && (ndone + nerr) == ends0; w++) begin
            @(negedge clk);
            if (walk_err && drain_chk) chk(!cmd_ready, "R7 drain", cmd_ready, 0);
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic cmp_run(input string tag, input int g0, input int r0, input int d0, input int x0);
        chk(gn - g0 == en, {tag, " count"}, gn - g0, en);
        for (int i = 0; i < en; i++) chk(got_addr[g0 + i] == exp_a[i], {tag, " addr"}, got_addr[g0 + i], exp_a[i]);
        chk(nreq - r0 == ereq, {tag, " reads"}, nreq - r0, ereq);
        chk((ndone - d0) + (nerr - x0) == 1, "R10 one end", (ndone - d0) + (nerr - x0), 1);
        chk((nerr - x0) == int'(e_err), {tag, " outcome"}, nerr - x0, e_err);
        chk(last_sts == (e_err ? 8'h04 : 8'h00), {tag, " status"}, last_sts, e_err ? 8'h04 : 8'h00);
    endtask

    // {prp1, prp2, len, error page}
    localparam logic [127:0] VEC [0:9] = '{
        {32'h0001_0000, 32'h0000_0000, 32'h0000_1000, 32'd8},
        {32'h0001_0800, 32'h0000_0000, 32'h0000_0800, 32'd8},
        {32'h0001_0800, 32'h0002_0000, 32'h0000_1000, 32'd8},
        {32'h0001_0000, 32'h0002_0000, 32'h0000_2000, 32'd8},
        {32'h0001_0000, 32'h0000_1000, 32'h0000_4000, 32'd8},
        {32'h0001_0000, 32'h0000_1000, 32'h0000_5000, 32'd8},
        {32'h0001_0000, 32'h0000_1000, 32'h0000_6000, 32'd8},
        {32'h0001_0100, 32'h0000_1000, 32'h0000_A001, 32'd8},
        {32'h0001_0000, 32'h0000_1000, 32'h0000_6000, 32'd1},
        {32'h0001_0000, 32'h0000_1000, 32'h0000_6000, 32'd2}
    };

    function automatic string tag_of(input int i);
        case (i)
            0, 1:    return "R3";
            2, 3:    return "R4";
            4:       return "R5";
            5, 6, 7: return "R6";
            default: return "R7";
        endcase
    endfunction

    bit finished = 0;
    initial begin
        #(8 * 150000);
        if (!finished) begin
            nchk++; nfail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

    initial begin
        int g0, r0, d0, x0;
        // R1 reset state
        repeat (3) @(negedge clk);
        chk(cmd_ready == 1'b1, "R1 cmd_ready", cmd_ready, 1);
        chk(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
        chk(rd_req_valid == 1'b0, "R1 rd_req_valid", rd_req_valid, 0);
        chk(!walk_done && !walk_err, "R1 pulses", {walk_done, walk_err}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(cmd_ready && !out_valid && !rd_req_valid, "R1 after release", {cmd_ready, out_valid, rd_req_valid}, 3'b100);

        // R2 zero length
        g0 = gn; r0 = nreq; d0 = ndone; x0 = nerr; en = 0; ereq = 0;
        ref_walk(64'h1_0000, 64'h2_0000, 0, 8);
        send_cmd(64'h1_0000, 64'h2_0000, 32'd0);
        wait_end(d0 + x0, 1'b0);
        cmp_run("R2", g0, r0, d0, x0);

        // table of vectors
        for (int v = 0; v < 10; v++) begin
            g0 = gn; r0 = nreq; d0 = ndone; x0 = nerr; en = 0; ereq = 0;
            err_page = VEC[v][3:0];
            ref_walk(64'(VEC[v][127:96]), 64'(VEC[v][95:64]), VEC[v][63:32], int'(VEC[v][31:0]));
            send_cmd(64'(VEC[v][127:96]), 64'(VEC[v][95:64]), VEC[v][63:32]);
            wait_end(d0 + x0, (v == 8));
            cmp_run(tag_of(v), g0, r0, d0, x0);
            if (v == 4) begin
                chk(last_req_addr == 64'h1000, "R5 req addr", last_req_addr, 64'h1000);
                chk(last_req_cnt == 3, "R5 req cnt", last_req_cnt, 3);
            end
            if (v == 6) chk(last_req_cnt == 2, "R6 chained cnt", last_req_cnt, 2);
        end
        err_page = 4'd8;

        // R9 next command held during a chained walk, taken in the done cycle
        g0 = gn; r0 = nreq; d0 = ndone; x0 = nerr; en = 0; ereq = 0;
        ref_walk(64'h1_0000, 64'h1000, 32'h6000, 8);
        ref_walk(64'h3_0000, 64'h4_0000, 32'h2000, 8);
        @(negedge clk);
        cmd_prp1 = 64'h1_0000; cmd_prp2 = 64'h1000; cmd_len = 32'h6000; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_prp1 = 64'h3_0000; cmd_prp2 = 64'h4_0000; cmd_len = 32'h2000;
        for (int w = 0; w < 5000 && !cmd_ready; w++) @(negedge clk);
        chk(walk_done == 1'b1, "R9 done with ready", walk_done, 1);
        @(negedge clk);
        cmd_valid = 1'b0;
        wait_end(d0 + x0 + 1, 1'b0);
        chk(gn - g0 == en, "R9 count", gn - g0, en);
        for (int i = 0; i < en; i++) chk(got_addr[g0 + i] == exp_a[i], "R9 addr", got_addr[g0 + i], exp_a[i]);
        chk(ndone - d0 == 2 && nerr == x0, "R10 two dones", ndone - d0, 2);
        chk(last_sts == 8'h00, "R9 status", last_sts, 0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule